// File: doc/BRIEF.md
# AES Key-Expansion Assist Unit

This unit performs the helper step of AES round-key expansion. It takes a 128-bit source operand and an 8-bit round constant. The operand is viewed as four 32-bit words, and the unit uses two of them: the word in bits 63:32 and the word in bits 127:96. Each of these two words is passed byte by byte through the forward AES S-box. The unit then emits two forms of each word: the plain substituted word, and the substituted word rotated by one byte and XORed with the round constant.

Software or a key-schedule sequencer combines the four result words into round keys for 128-, 192- and 256-bit keys. The unrotated forms are needed only by the extra substitution step of the 256-bit schedule. The unit sits behind a valid/ready handshake and uses a two-stage register pipeline. Back-pressure on the output freezes both stages.

Top module: `aes_keygen_assist`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Result bits 31:0 (Y0) equal SubWord(X1), where X1 is source bits 63:32 and SubWord applies the forward AES S-box to each byte. For example, S(0x00)=0x63 and S(0x53)=0xED.
- R3: Result bits 95:64 (Y2) equal SubWord(X3), where X3 is source bits 127:96.
- R4: Result bits 63:32 (Y1) equal RotWord(SubWord(X1)) XOR {24'h0, rcon}. RotWord turns the bytes [a0,a1,a2,a3] (a0 lowest) into [a1,a2,a3,a0].
- R5: Result bits 127:96 (Y3) equal RotWord(SubWord(X3)) XOR {24'h0, rcon}.
- R6: Source bits 31:0 and 95:64 have no effect on the result.
- R7: An operand accepted in cycle c (`in_valid` and `in_ready` both high) shows its result with `out_valid` high in cycle c+2, provided `in_ready` is high in cycle c+1. One operand can be accepted in every cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. In the next cycle `out_valid` stays 1 and `out_data` is unchanged.
- R9: Results leave in the order their operands were accepted. None is lost and none is duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_src | input | 128 | Source operand, four 32-bit words |
| in_rcon | input | 8 | Round-constant immediate |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | {Y3, Y2, Y1, Y0} |

## Verification
Accepting a new operand and holding a stalled result can fall in the same cycle. This happens when the output stage is full and `out_ready` drops while `in_valid` is still high. Random phases toggle both handshakes independently to provoke this case. A directed phase fills both stages under a held-low `out_ready`. The bench judges it by requiring `in_ready` low, an unchanged `out_data`, and a scoreboard that sees every accepted operand exactly once and in order after the stall is released.

// File: rtl/aes_kga_pkg.sv
package aes_kga_pkg;

  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic loadS1;
    logic loadS2;
  } kgaStrobes_t;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // inverse as a^254; zero maps to zero
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] base;
    logic [7:0] ex;
    res  = 8'h01;
    base = a;
    ex   = 8'hFE;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) res = gfMul(res, base);
      base = gfMul(base, base);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  function automatic logic [7:0] sboxCalc(input logic [7:0] b);
    logic [7:0] q;
    q = gfInv(b);
    return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
  endfunction

  function automatic logic [255:0][7:0] sboxTable();
    logic [255:0][7:0] t;
    for (int i = 0; i < 256; i++) t[i] = sboxCalc(8'(i));
    return t;
  endfunction

endpackage

// File: rtl/aes_kga_sbox.sv
module aes_kga_sbox
  import aes_kga_pkg::*;
#(
  parameter int SBOX_STYLE = 0  // 0: constant table, 1: inversion logic
) (
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);

  generate
    if (SBOX_STYLE == 0) begin : gTable
      localparam logic [255:0][7:0] SBOX_ROM = sboxTable();
      always_comb byteOut = SBOX_ROM[byteIn];
    end else begin : gLogic
      always_comb byteOut = sboxCalc(byteIn);
    end
  endgenerate

endmodule

// File: rtl/aes_kga_ctrl.sv
module aes_kga_ctrl
  import aes_kga_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output kgaStrobes_t strobes
);

  logic s1Valid;
  logic s2Valid;
  logic advance;

  always_comb begin
    advance        = !s2Valid || outReady;
    inReady        = advance;
    outValid       = s2Valid;
    strobes.loadS1 = advance && inValid;
    strobes.loadS2 = advance && s1Valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else if (advance) begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
    end
  end

endmodule

// File: rtl/aes_kga_datapath.sv
module aes_kga_datapath
  import aes_kga_pkg::*;
#(
  parameter int SBOX_STYLE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  kgaStrobes_t            strobes,
  input  logic [4*WORD_W-1:0]    srcIn,
  input  logic [BYTE_W-1:0]      rconIn,
  output logic [4*WORD_W-1:0]    resOut
);

  localparam int BYTES = WORD_W / BYTE_W;

  // stage 1: selected source words and constant
  logic [NUM_SRC-1:0][WORD_W-1:0] srcQ;
  logic [BYTE_W-1:0]              rconQ;
  logic [NUM_SRC-1:0][WORD_W-1:0] subW;
  logic [NUM_SRC-1:0][WORD_W-1:0] rotW;
  logic [4*WORD_W-1:0]            resD;
  logic [4*WORD_W-1:0]            resQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcQ  <= '0;
      rconQ <= '0;
    end else if (strobes.loadS1) begin
      srcQ[0] <= srcIn[2*WORD_W-1:WORD_W];
      srcQ[1] <= srcIn[4*WORD_W-1:3*WORD_W];
      rconQ   <= rconIn;
    end
  end

  genvar w, b;
  generate
    for (w = 0; w < NUM_SRC; w++) begin : gWord
      for (b = 0; b < BYTES; b++) begin : gByte
        aes_kga_sbox #(.SBOX_STYLE(SBOX_STYLE)) uSbox (
          .byteIn (srcQ[w][b*BYTE_W +: BYTE_W]),
          .byteOut(subW[w][b*BYTE_W +: BYTE_W])
        );
      end
      always_comb begin
        rotW[w] = {subW[w][BYTE_W-1:0], subW[w][WORD_W-1:BYTE_W]}
                  ^ {{(WORD_W-BYTE_W){1'b0}}, rconQ};
        resD[(2*w)*WORD_W   +: WORD_W] = subW[w];
        resD[(2*w+1)*WORD_W +: WORD_W] = rotW[w];
      end
    end
  endgenerate

  // stage 2: result register
  always_ff @(posedge clk) begin
    if (!rst_n)              resQ <= '0;
    else if (strobes.loadS2) resQ <= resD;
  end

  assign resOut = resQ;

endmodule

// File: rtl/aes_keygen_assist.sv
module aes_keygen_assist
  import aes_kga_pkg::*;
#(
  parameter int SBOX_STYLE = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_src,
  input  logic [7:0]   in_rcon,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data
);

  kgaStrobes_t strobes;

  aes_kga_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .outReady (out_ready),
    .inReady  (in_ready),
    .outValid (out_valid),
    .strobes  (strobes)
  );

  aes_kga_datapath #(.SBOX_STYLE(SBOX_STYLE)) uData (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .srcIn   (in_src),
    .rconIn  (in_rcon),
    .resOut  (out_data)
  );

endmodule

// File: rtl/aes_kga_checker.sv
module aes_kga_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_data
);

  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready |=> out_valid); // R7

  AST_LOW_PAIR_ROTATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[63:40] == {out_data[7:0], out_data[31:16]})); // R4

  AST_HIGH_PAIR_ROTATED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[127:104] == {out_data[71:64], out_data[95:80]})); // R5

  AST_SHARED_CONSTANT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data[39:32] ^ out_data[15:8]) ==
                   (out_data[103:96] ^ out_data[79:72]))); // R4

endmodule

bind aes_keygen_assist aes_kga_checker uChecker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_aes_keygen_assist.sv
`timescale 1ns/1ps
module tb_aes_keygen_assist;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_src;
  logic [7:0]   in_rcon;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;

  int checks = 0;
  int fails  = 0;
  int pushed = 0;
  int popped = 0;
  logic [127:0] expQ[$];
  logic [127:0] lastPop, prevPop;
  logic [7:0]   sb[256];
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  aes_keygen_assist dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_rcon(in_rcon), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] mulRef(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] p = 16'h0;
    for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] sbRef(input logic [7:0] v);
    logic [7:0] inv = 8'h00;
    logic [7:0] r;
    logic [7:0] c = 8'h63;
    for (int k = 1; k < 256; k++) if (mulRef(v, 8'(k)) == 8'h01) inv = 8'(k);
    for (int i = 0; i < 8; i++)
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return r;
  endfunction

  function automatic logic [31:0] subRef(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [127:0] expRef(input logic [127:0] s, input logic [7:0] rc);
    logic [31:0] a = subRef(s[63:32]);
    logic [31:0] c = subRef(s[127:96]);
    logic [31:0] ra = {a[7:0], a[31:24], a[23:16], a[15:8]} ^ {24'h0, rc};
    logic [31:0] rcw = {c[7:0], c[31:24], c[23:16], c[15:8]} ^ {24'h0, rc};
    return {rcw, c, ra, a};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge and account for the coming handshakes
  task automatic drive(input logic v, input logic [127:0] s, input logic [7:0] rc, input logic ordy);
    logic [127:0] e;
    @(negedge clk);
    in_valid = v; in_src = s; in_rcon = rc; out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      e = (expQ.size() > 0) ? expQ.pop_front() : 128'hx;
      chk("R2 Y0", {96'h0, out_data[31:0]},   {96'h0, e[31:0]});
      chk("R4 Y1", {96'h0, out_data[63:32]},  {96'h0, e[63:32]});
      chk("R3 Y2", {96'h0, out_data[95:64]},  {96'h0, e[95:64]});
      chk("R5 Y3", {96'h0, out_data[127:96]}, {96'h0, e[127:96]});
      prevPop = lastPop; lastPop = out_data; popped++;
    end
    if (in_valid && in_ready) begin
      expQ.push_back(expRef(in_src, in_rcon));
      pushed++;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    logic [127:0] held;
    logic [127:0] base;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) sb[i] = sbRef(8'(i));
    chk("R2 sbox 00", {120'h0, sb[8'h00]}, {120'h0, 8'h63});
    chk("R2 sbox 53", {120'h0, sb[8'h53]}, {120'h0, 8'hED});

    rst_n = 1'b0; in_valid = 1'b0; in_src = '0; in_rcon = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {127'h0, out_valid}, 128'h0);
    chk("R1 reset in_ready",  {127'h0, in_ready},  128'h1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 post-reset out_valid", {127'h0, out_valid}, 128'h0);
    chk("R1 post-reset in_ready",  {127'h0, in_ready},  128'h1);

    // R7 latency from an empty pipeline
    drive(1'b1, {32'h0, 32'hDEADBEEF, 32'h0, 32'h0}, 8'h01, 1'b1);
    drive(1'b0, '0, '0, 1'b1);
    chk("R7 not yet valid", {127'h0, out_valid}, 128'h0);
    drive(1'b0, '0, '0, 1'b1);
    chk("R7 valid at c+2", {127'h0, out_valid}, 128'h1);
    chk("R4 zero operand", lastPop, {32'h63636362, 32'h63636363, 32'h63636362, 32'h63636363});

    // R6: only words 0 and 2 differ between the two operands
    base = {32'h01234567, 32'h0, 32'h89ABCDEF, 32'h0};
    drive(1'b1, base, 8'h36, 1'b1);
    drive(1'b1, base | {32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF}, 8'h36, 1'b1);
    repeat (3) drive(1'b0, '0, '0, 1'b1);
    chk("R6 ignored words", lastPop, prevPop);

    // corner constants and all-ones operand
    drive(1'b1, {128{1'b1}}, 8'hFF, 1'b1);
    drive(1'b1, {32'h00010203, 32'h0, 32'hFCFDFEFF, 32'h0}, 8'h00, 1'b1);
    drive(1'b1, {32'h80808080, 32'h0, 32'h1B1B1B1B, 32'h0}, 8'h80, 1'b1);
    repeat (3) drive(1'b0, '0, '0, 1'b1);

    // R8 stall with both stages full and input still offered
    drive(1'b1, {4{32'h11223344}}, 8'h02, 1'b0);
    drive(1'b1, {4{32'h55667788}}, 8'h04, 1'b0);
    drive(1'b1, {4{32'h99AABBCC}}, 8'h08, 1'b0);
    chk("R8 in_ready low", {127'h0, in_ready}, 128'h0);
    held = out_data;
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, {4{32'($urandom)}}, 8'h10, 1'b0);
      chk("R8 data held", out_data, held);
      chk("R8 valid held", {127'h0, out_valid}, 128'h1);
    end
    repeat (4) drive(1'b0, '0, '0, 1'b1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [127:0] s;
      s = {$urandom, $urandom, $urandom, $urandom};
      drive(($urandom % 10) < 7, s, 8'($urandom), ($urandom % 10) < 7);
    end
    repeat (6) drive(1'b0, '0, '0, 1'b1);
    chk("R9 queue empty", 128'(expQ.size()), 128'h0);
    chk("R9 counts match", 128'(popped), 128'(pushed));

    done = 1'b1;
    finishRun();
  end

endmodule